// File: doc/BRIEF.md
# Grouped Parallel-Prefix Binary Adder

This block adds two unsigned N-bit operands and returns the N-bit sum and a carry-out, all in a single combinational path. Each bit position first forms a propagate flag (the XOR of its operand bits) and a generate flag (their AND). The carries come from a network of associative combining cells that merge (generate, propagate) pairs. The sum bit at each position is its propagate flag XOR the carry out of the position just below. Position 0 sees a carry of zero.

The N positions are split into N/M groups of M bits. Inside a group, every position gets its own logarithmic tree that merges all lower positions of that group. Positions near the group base need fewer cells, and the cells that would reach below the base pass their value straight through. Between groups, one combining level per group carries the running result upward, so that chain grows linearly with the number of groups. With M = N the whole adder is a single tree of depth ceil(log2 N). With M = 1 it reduces to a ripple chain. Any M that divides N yields the same arithmetic result. A configuration where M does not divide N, or N < 2, is refused at elaboration.

Top module: `pfx_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i`) modulo 2^N for every pair of operands.
- R2: `cout_o` equals bit N of the full (N+1)-bit sum `a_i` + `b_i`.
- R3: No carry enters position 0, so `sum_o[0]` always equals `a_i[0]` XOR `b_i[0]`.
- R4: When every position propagates (`b_i` = ~`a_i`), `sum_o` is all ones and `cout_o` is 0.
- R5: A carry generated at position 0 that propagates through every higher position (all-ones plus one) gives `sum_o` = 0 and `cout_o` = 1, crossing every group boundary.
- R6: For every legal group size M (1, any divisor of N, and N itself), the outputs are identical for identical operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand, unsigned |
| b_i | input | N | Second operand, unsigned |
| sum_o | output | N | Sum modulo 2^N |
| cout_o | output | 1 | Carry out of the top position |

## Verification
Two carry mechanisms can decide the same sum bit together: the in-group prefix tree and the group-to-group link chain. They meet whenever a carry born in a low group has to pass through whole higher groups before it reaches a bit whose own tree also spans several positions. The bench provokes this with full-propagate runs that are fed by a generate at position 0, and with mixed patterns whose generates sit just below group boundaries. Ten adders with different group sizes are driven side by side, and each result is judged against a plain behavioural (N+1)-bit addition.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  // generate / propagate pair carried through the prefix network
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // associative combining cell: upper span (hi) absorbs lower span (lo)
  function automatic gp_t gp_join(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/pfx_bit_gp.sv
module pfx_bit_gp
  import pfx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output gp_t  [W-1:0] gp_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gp_o[i].g = a_i[i] & b_i[i];
    assign gp_o[i].p = a_i[i] ^ b_i[i];
  end

endmodule

// File: rtl/pfx_group_tree.sv
module pfx_group_tree
  import pfx_pkg::*;
#(
  parameter int M = 4
) (
  input  gp_t [M-1:0] leaf_i,
  output gp_t [M-1:0] pre_o
);

  localparam int LV = (M > 1) ? $clog2(M) : 0;

  // one shifted tree per position; spans reaching below the group base
  // are dropped and the value passes through unchanged (duplication)
  always_comb begin
    gp_t [M-1:0] cur;
    gp_t [M-1:0] nxt;
    cur = leaf_i;
    for (int l = 0; l < LV; l++) begin
      nxt = cur;
      for (int i = 0; i < M; i++) begin
        if (i >= (1 << l)) begin
          nxt[i] = gp_join(cur[i], cur[i - (1 << l)]);
        end
      end
      cur = nxt;
    end
    pre_o = cur;
  end

  // group-level propagate must be the AND of every leaf propagate (R6)
  always_comb begin
    logic all_p;
    all_p = 1'b1;
    for (int i = 0; i < M; i++) begin
      all_p = all_p & leaf_i[i].p;
    end
    assert_grp_prop_R6: assert (pre_o[M-1].p == all_p)
      else $error("group propagate mismatch");
    if (pre_o[M-1].p) begin
      assert_grp_quiet_R4: assert (!pre_o[M-1].g)
        else $error("full-propagate group reports generate");
    end
  end

endmodule

// File: rtl/pfx_group_link.sv
module pfx_group_link
  import pfx_pkg::*;
#(
  parameter int M = 4
) (
  input  gp_t [M-1:0] pre_i,
  input  logic        cin_i,
  output logic [M-1:0] carry_o,
  output logic         cout_o
);

  // one combining level folds the incoming group carry into each prefix
  for (genvar j = 0; j < M; j++) begin : g_fold
    assign carry_o[j] = pre_i[j].g | (pre_i[j].p & cin_i);
  end

  assign cout_o = pre_i[M-1].g | (pre_i[M-1].p & cin_i);

  // with no carry entering, bit carries are purely the in-group generates (R5)
  always_comb begin
    if (!cin_i) begin
      for (int j = 0; j < M; j++) begin
        assert_link_local_R5: assert (carry_o[j] == pre_i[j].g)
          else $error("carry without group input differs from prefix");
      end
    end
  end

endmodule

// File: rtl/pfx_adder.sv
module pfx_adder
  import pfx_pkg::*;
#(
  parameter int N = 16,
  parameter int M = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);

  localparam int Q = (M > 0) ? (N / M) : 1;

  if ((M < 1) || (N < 2) || ((N % M) != 0)) begin : g_bad_cfg
    $error("pfx_adder: group size must divide operand width");
  end

  gp_t [N-1:0] gp;
  logic [N-1:0] p_vec;
  logic [N-1:0] c_bit;
  logic [Q:0]   c_grp;

  pfx_bit_gp #(.W(N)) u_gp (
    .a_i  (a_i),
    .b_i  (b_i),
    .gp_o (gp)
  );

  assign c_grp[0] = 1'b0;

  for (genvar k = 0; k < Q; k++) begin : g_grp
    gp_t [M-1:0] pre;

    pfx_group_tree #(.M(M)) u_tree (
      .leaf_i (gp[k*M +: M]),
      .pre_o  (pre)
    );

    pfx_group_link #(.M(M)) u_link (
      .pre_i   (pre),
      .cin_i   (c_grp[k]),
      .carry_o (c_bit[k*M +: M]),
      .cout_o  (c_grp[k+1])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_p
    assign p_vec[i] = gp[i].p;
  end

  assign sum_o  = p_vec ^ {c_bit[N-2:0], 1'b0};
  assign cout_o = c_grp[Q];

  always_comb begin
    assert_sum_R1: assert (sum_o == (a_i + b_i))
      else $error("sum differs from modular addition");
    assert_cout_R2: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}))
      else $error("carry-out differs from full addition");
    assert_lsb_R3: assert (sum_o[0] == (a_i[0] ^ b_i[0]))
      else $error("carry leaked into position 0");
  end

endmodule

// File: tb/sim_pfx_adder.sv
module sim_pfx_adder;

  logic clk;
  logic rst_n;
  int   n_chk;
  int   n_bad;
  bit   done;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] a16, b16;
  logic [23:0] a24, b24;
  logic [15:0] s16 [5];
  logic        c16 [5];
  logic [23:0] s24 [5];
  logic        c24 [5];

  pfx_adder #(.N(16), .M(4))  u0    (.a_i(a16), .b_i(b16), .sum_o(s16[0]), .cout_o(c16[0]));
  pfx_adder #(.N(16), .M(1))  u1_16 (.a_i(a16), .b_i(b16), .sum_o(s16[1]), .cout_o(c16[1]));
  pfx_adder #(.N(16), .M(2))  u2_16 (.a_i(a16), .b_i(b16), .sum_o(s16[2]), .cout_o(c16[2]));
  pfx_adder #(.N(16), .M(8))  u8_16 (.a_i(a16), .b_i(b16), .sum_o(s16[3]), .cout_o(c16[3]));
  pfx_adder #(.N(16), .M(16)) uf_16 (.a_i(a16), .b_i(b16), .sum_o(s16[4]), .cout_o(c16[4]));

  pfx_adder #(.N(24), .M(1))  u1_24 (.a_i(a24), .b_i(b24), .sum_o(s24[0]), .cout_o(c24[0]));
  pfx_adder #(.N(24), .M(2))  u2_24 (.a_i(a24), .b_i(b24), .sum_o(s24[1]), .cout_o(c24[1]));
  pfx_adder #(.N(24), .M(4))  u4_24 (.a_i(a24), .b_i(b24), .sum_o(s24[2]), .cout_o(c24[2]));
  pfx_adder #(.N(24), .M(8))  u8_24 (.a_i(a24), .b_i(b24), .sum_o(s24[3]), .cout_o(c24[3]));
  pfx_adder #(.N(24), .M(24)) uf_24 (.a_i(a24), .b_i(b24), .sum_o(s24[4]), .cout_o(c24[4]));

  // stimulus table: {a, b}, 16 bits each; 24-bit runs widen a and b
  localparam logic [31:0] TAB [12] = '{
    {16'h0000, 16'h0000},
    {16'h0001, 16'h0001},
    {16'h000F, 16'h0001},   // carry leaves group of 4
    {16'h00FF, 16'h0001},   // carry leaves group of 8
    {16'h7FFF, 16'h0001},
    {16'h8000, 16'h8000},   // only top generates
    {16'hFFFF, 16'h0000},
    {16'h1234, 16'hEDCC},
    {16'hA5A5, 16'h5A5B},
    {16'h0F0F, 16'h0F0F},
    {16'hC3C3, 16'h3C3C},
    {16'h8421, 16'h7BDF}
  };

  task automatic chk(input string req, input logic [24:0] got, input logic [24:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run16(input logic [15:0] a, input logic [15:0] b, input string req);
    logic [16:0] exp;
    @(posedge clk);
    a16 = a;
    b16 = b;
    @(negedge clk);
    exp = {1'b0, a} + {1'b0, b};
    for (int k = 0; k < 5; k++) begin
      chk(req, {8'h00, c16[k], s16[k]}, {8'h00, exp});
    end
  endtask

  task automatic run24(input logic [23:0] a, input logic [23:0] b, input string req);
    logic [24:0] exp;
    @(posedge clk);
    a24 = a;
    b24 = b;
    @(negedge clk);
    exp = {1'b0, a} + {1'b0, b};
    for (int k = 0; k < 5; k++) begin
      chk(req, {c24[k], s24[k]}, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    a16 = '0; b16 = '0; a24 = '0; b24 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // initial state with zero operands: R1 R2
    @(negedge clk);
    chk("R1 zero operands", {9'h000, s16[0]}, 25'h0);
    chk("R2 zero operands", {24'h0, c16[0]}, 25'h0);

    // table walk: R1 R2
    for (int t = 0; t < 12; t++) begin
      run16(TAB[t][31:16], TAB[t][15:0], "R1 R2 table16");
      run24({TAB[t][23:16], TAB[t][31:16]}, {TAB[t][7:0], TAB[t][15:0]}, "R1 R2 table24");
    end

    // R3: lowest sum bit sees no carry
    @(posedge clk); a16 = 16'h0001; b16 = 16'h0001;
    @(negedge clk);
    for (int k = 0; k < 5; k++) chk("R3 lsb 1+1", {24'h0, s16[k][0]}, 25'h0);
    @(posedge clk); a16 = 16'hFFFF; b16 = 16'h0000;
    @(negedge clk);
    for (int k = 0; k < 5; k++) chk("R3 lsb 1+0", {24'h0, s16[k][0]}, 25'h1);

    // R4: every position propagates
    @(posedge clk); a16 = 16'h5A5A; b16 = 16'hA5A5; a24 = 24'h3C96A5; b24 = ~24'h3C96A5;
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      chk("R4 propagate16", {8'h00, c16[k], s16[k]}, {9'h000, 16'hFFFF});
      chk("R4 propagate24", {c24[k], s24[k]}, {1'b0, 24'hFFFFFF});
    end

    // R5: generate at bit 0 carried through every group
    @(posedge clk); a16 = 16'hFFFF; b16 = 16'h0001; a24 = 24'hFFFFFF; b24 = 24'h000001;
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      chk("R5 full chain16", {8'h00, c16[k], s16[k]}, {8'h00, 1'b1, 16'h0000});
      chk("R5 full chain24", {c24[k], s24[k]}, {1'b1, 24'h000000});
    end
    run16(16'hFFFF, 16'hFFFF, "R5 all generate16");
    run24(24'hFFFFFF, 24'hFFFFFF, "R5 all generate24");

    // R6: pseudo-random operands, every group size against the same reference
    lfsr = 32'hACE1_1234;
    for (int r = 0; r < 300; r++) begin
      logic [15:0] ra;
      logic [15:0] rb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = lfsr[15:0];
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rb = lfsr[31:16];
      run16(ra, rb, "R6 random16");
      run24({rb[7:0], ra}, {ra[15:8], rb}, "R6 random24");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule